// File: doc/BRIEF.md
# Forwarded-Clock Edge Search Controller

This controller brings a capture clock into a known phase relationship with a forwarded source-synchronous bit clock. A monitor copy of the capture clock, 90 degrees later than the data capture clock, samples the forwarded clock into parallel words. The controller steps a clock synthesizer's dynamic fine phase shifter one increment at a time. After each step it judges whether the monitor words are steady or unsteady. An unsteady result means the monitor is sampling on a transition of the forwarded clock.

A search starts from the current phase and moves forward until the words turn unsteady. It keeps moving forward across the unsteady region, counting its width, until it reaches the first steady position on the far side. It then steps back by half of that width, rounded up, and reports lock. Because the data capture clock and the slower word-domain clock share the adjusted phase, placing the monitor on the edge puts data capture in the middle of the bit. When the shift is applied to the synthesizer's feedback path, the output clocks move opposite to the requested direction. An input therefore inverts the controller's direction sense. If no far boundary is reached within a programmable number of forward steps, the search stops and flags an error.

Top module: `esc_edge_search`

## Requirements
- R1: After reset, ps_en, busy, aligned and search_err are 0 and phase_pos is 0.
- R2: A start pulse while not busy raises busy on the next cycle and clears aligned, search_err and phase_pos. busy stays high, and aligned and search_err stay low, until the search ends.
- R3: Each phase step is requested by a ps_en pulse lasting exactly one cycle, with ps_dir valid in that cycle. No further ps_en is issued until ps_done has returned for the outstanding request.
- R4: A forward step drives ps_dir=1 when invert_dir=0 and ps_dir=0 when invert_dir=1. A retreat step drives the opposite level.
- R5: After start and after every completed step, the first 8 words with cap_valid high are discarded before judging.
- R6: A judgement examines the next 32 words with cap_valid high and ignores words with cap_valid low. The position is unsteady if any examined word is neither the alternating pattern with bit 0 set (0x55 at width 8) nor its complement (0xAA), or if it differs from the previous examined word.
- R7: While no unsteady position has been seen, a steady judgement causes one forward step. From the first unsteady judgement on, every unsteady judgement causes one forward step and adds one to the region width w.
- R8: The first steady judgement after the unsteady region causes ceil(w/2) consecutive retreat steps with no judging between them. aligned then rises and busy falls, and phase_pos ends at first_unsteady + w - ceil(w/2).
- R9: At most max_steps forward steps are taken in one search. When another forward step would be needed beyond that count, search_err rises, busy falls and no step is issued.
- R10: A max_steps value of 0 selects a limit of 1120 forward steps.
- R11: phase_pos is a signed count, since the last start, of completed forward steps minus completed retreat steps. It updates when ps_done is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (word domain) |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search from the present phase |
| invert_dir | input | 1 | Invert ps_dir sense for feedback-path shifting |
| max_steps | input | SW | Forward step limit, 0 selects the default |
| cap_valid | input | 1 | cap_word carries a new monitor word |
| cap_word | input | W | Forwarded clock captured by the 90-degree monitor clock |
| ps_done | input | 1 | Phase shifter has finished the requested step |
| ps_en | output | 1 | One-cycle phase-step request |
| ps_dir | output | 1 | Direction of the requested step |
| busy | output | 1 | Search in progress |
| aligned | output | 1 | Search ended on the computed offset |
| search_err | output | 1 | Step limit reached without a far boundary |
| phase_pos | output | SW+1 | Signed net step count since start |

## Verification
Each search is driven by a shifter model that places an unsteady region at chosen offsets and widths. Inside that region, words either flicker between the two legal patterns, which exercises the predecessor comparison, or hold an illegal constant, which exercises the pattern comparison. Outside the region the steady pattern is 0x55 or 0xAA depending on the case. Every settling period is filled with garbage words and every invalid cycle carries garbage, so a controller that judged too early or counted invalid words would lock at the wrong phase. Runs with a region starting at zero, a single-step region, an exact limit hit, one step past the limit, inverted direction and the default limit with no edge at all separate the offset arithmetic from the limit handling.

// File: rtl/esc_pkg.sv
package esc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MEAS,
    ST_STEP,
    ST_LOCK,
    ST_FAIL
  } ctl_state_t;

  typedef enum logic [1:0] {
    PH_FIND,
    PH_CROSS,
    PH_BACK
  } search_phase_t;
endpackage

// File: rtl/esc_word_judge.sv
module esc_word_judge #(
  parameter int W            = 8,
  parameter int SETTLE_WORDS = 8,
  parameter int OBS_WORDS    = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic         valid,
  input  logic [W-1:0] word,
  output logic         done,
  output logic         unsteady
);
  localparam int SC_W = $clog2(SETTLE_WORDS + 1);
  localparam int OC_W = $clog2(OBS_WORDS + 1);

  logic [W-1:0] pat_a;
  logic [W-1:0] pat_b;
  for (genvar i = 0; i < W; i++) begin : g_pat
    assign pat_a[i] = (i % 2 == 0);
  end
  assign pat_b = ~pat_a;

  typedef enum logic [1:0] {J_IDLE, J_SETTLE, J_OBS} judge_st_t;
  judge_st_t    jst;
  logic [SC_W-1:0] s_cnt;
  logic [OC_W-1:0] o_cnt;
  logic [W-1:0] prev;
  logic         bad_acc;
  logic         w_bad;

  always_comb begin
    w_bad = !((word == pat_a) || (word == pat_b));
    if ((o_cnt != '0) && (word != prev)) w_bad = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      jst      <= J_IDLE;
      s_cnt    <= '0;
      o_cnt    <= '0;
      prev     <= '0;
      bad_acc  <= 1'b0;
      done     <= 1'b0;
      unsteady <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        jst     <= J_SETTLE;
        s_cnt   <= '0;
        o_cnt   <= '0;
        bad_acc <= 1'b0;
      end else if (valid) begin
        case (jst)
          J_SETTLE: begin
            if (s_cnt == SC_W'(SETTLE_WORDS - 1)) jst <= J_OBS;
            s_cnt <= s_cnt + 1'b1;
          end
          J_OBS: begin
            prev  <= word;
            o_cnt <= o_cnt + 1'b1;
            if (o_cnt == OC_W'(OBS_WORDS - 1)) begin
              jst      <= J_IDLE;
              done     <= 1'b1;
              unsteady <= bad_acc | w_bad;
            end else begin
              bad_acc <= bad_acc | w_bad;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_JUDGE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
endmodule

// File: rtl/esc_phase_stepper.sv
module esc_phase_stepper #(
  parameter int PW = 17
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clear,
  input  logic                 req,
  input  logic                 fwd,
  input  logic                 dir_inv,
  output logic                 ps_en,
  output logic                 ps_dir,
  input  logic                 ps_done,
  output logic                 step_done,
  output logic signed [PW-1:0] pos
);
  logic pending;
  logic fwd_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      ps_en     <= 1'b0;
      ps_dir    <= 1'b0;
      pending   <= 1'b0;
      fwd_r     <= 1'b0;
      step_done <= 1'b0;
      pos       <= '0;
    end else begin
      ps_en     <= 1'b0;
      step_done <= 1'b0;
      if (clear) pos <= '0;
      if (req && !pending) begin
        ps_en   <= 1'b1;
        ps_dir  <= fwd ^ dir_inv;
        fwd_r   <= fwd;
        pending <= 1'b1;
      end else if (pending && ps_done) begin
        pending   <= 1'b0;
        step_done <= 1'b1;
        pos       <= fwd_r ? pos + PW'(1) : pos - PW'(1);
      end
    end
  end

  AST_EN_PULSE: assert property (@(posedge clk) disable iff (rst)
    ps_en |=> !ps_en); // R3
  AST_NO_REQ_PENDING: assert property (@(posedge clk) disable iff (rst)
    pending |-> !req); // R3
endmodule

// File: rtl/esc_edge_search.sv
module esc_edge_search #(
  parameter int W             = 8,
  parameter int SETTLE_WORDS  = 8,
  parameter int OBS_WORDS     = 32,
  parameter int SW            = 16,
  parameter int DEF_MAX_STEPS = 1120
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 invert_dir,
  input  logic [SW-1:0]        max_steps,
  input  logic                 cap_valid,
  input  logic [W-1:0]         cap_word,
  input  logic                 ps_done,
  output logic                 ps_en,
  output logic                 ps_dir,
  output logic                 busy,
  output logic                 aligned,
  output logic                 search_err,
  output logic signed [SW:0]   phase_pos
);
  import esc_pkg::*;
  localparam int PW = SW + 1;

  ctl_state_t    st;
  search_phase_t ph;
  logic [SW-1:0] steps;
  logic [SW-1:0] width;
  logic [SW-1:0] back_left;
  logic [SW-1:0] limit;
  logic          judge_go;
  logic          step_req;
  logic          step_fwd;
  logic          clr;
  logic          j_done;
  logic          j_unsteady;
  logic          s_done;
  logic          dir_inv_r;

  assign clr = start && !busy;

  esc_word_judge #(.W(W), .SETTLE_WORDS(SETTLE_WORDS), .OBS_WORDS(OBS_WORDS)) u_judge (
    .clk(clk), .rst(rst), .go(judge_go), .valid(cap_valid), .word(cap_word),
    .done(j_done), .unsteady(j_unsteady)
  );

  esc_phase_stepper #(.PW(PW)) u_step (
    .clk(clk), .rst(rst), .clear(clr), .req(step_req), .fwd(step_fwd),
    .dir_inv(dir_inv_r), .ps_en(ps_en), .ps_dir(ps_dir), .ps_done(ps_done),
    .step_done(s_done), .pos(phase_pos)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      ph         <= PH_FIND;
      steps      <= '0;
      width      <= '0;
      back_left  <= '0;
      limit      <= SW'(DEF_MAX_STEPS);
      judge_go   <= 1'b0;
      step_req   <= 1'b0;
      step_fwd   <= 1'b0;
      busy       <= 1'b0;
      aligned    <= 1'b0;
      search_err <= 1'b0;
      dir_inv_r  <= 1'b0;
    end else begin
      judge_go <= 1'b0;
      step_req <= 1'b0;
      case (st)
        ST_MEAS: begin
          if (j_done) begin
            if (ph == PH_CROSS && !j_unsteady) begin
              ph        <= PH_BACK;
              back_left <= (width >> 1) + {{(SW-1){1'b0}}, width[0]};
              step_req  <= 1'b1;
              step_fwd  <= 1'b0;
              st        <= ST_STEP;
            end else if (steps >= limit) begin
              st         <= ST_FAIL;
              search_err <= 1'b1;
              busy       <= 1'b0;
            end else begin
              if (j_unsteady) begin
                ph    <= PH_CROSS;
                width <= width + 1'b1;
              end
              steps    <= steps + 1'b1;
              step_req <= 1'b1;
              step_fwd <= 1'b1;
              st       <= ST_STEP;
            end
          end
        end
        ST_STEP: begin
          if (s_done) begin
            if (ph == PH_BACK) begin
              if (back_left == SW'(1)) begin
                st      <= ST_LOCK;
                aligned <= 1'b1;
                busy    <= 1'b0;
              end else begin
                back_left <= back_left - 1'b1;
                step_req  <= 1'b1;
                step_fwd  <= 1'b0;
              end
            end else begin
              judge_go <= 1'b1;
              st       <= ST_MEAS;
            end
          end
        end
        default: begin
          if (clr) begin
            st         <= ST_MEAS;
            ph         <= PH_FIND;
            steps      <= '0;
            width      <= '0;
            limit      <= (max_steps == '0) ? SW'(DEF_MAX_STEPS) : max_steps;
            dir_inv_r  <= invert_dir;
            judge_go   <= 1'b1;
            busy       <= 1'b1;
            aligned    <= 1'b0;
            search_err <= 1'b0;
          end
        end
      endcase
    end
  end

  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(aligned && search_err)); // R9
  AST_BUSY_CLEAN: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!aligned && !search_err)); // R2
  AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (rst)
    busy |-> (steps <= limit)); // R9
  AST_LOCK_AFTER_STEP: assert property (@(posedge clk) disable iff (rst)
    $rose(aligned) |-> $past(s_done)); // R8
endmodule

// File: tb/sim_esc_edge_search.sv
module sim_esc_edge_search;
  localparam int W  = 8;
  localparam int SW = 16;

  logic clk = 1'b0;
  logic rst, start, invert_dir, cap_valid, ps_done;
  logic [SW-1:0] max_steps;
  logic [W-1:0]  cap_word;
  logic ps_en, ps_dir, busy, aligned, search_err;
  logic signed [SW:0] phase_pos;

  always #2 clk = ~clk;

  esc_edge_search #(.W(W), .SW(SW)) u0 (
    .clk(clk), .rst(rst), .start(start), .invert_dir(invert_dir),
    .max_steps(max_steps), .cap_valid(cap_valid), .cap_word(cap_word),
    .ps_done(ps_done), .ps_en(ps_en), .ps_dir(ps_dir), .busy(busy),
    .aligned(aligned), .search_err(search_err), .phase_pos(phase_pos)
  );

  int n_chk = 0, n_bad = 0;
  // shifter / source model state
  int pos = 0, garb = 0, dly = 0, cyc = 0, viol = 0;
  bit pend = 0, pdir = 0, flip = 0, first_seen = 0, first_dir = 0;
  int r_lo = 0, r_w = 0, r_mode = 0;
  bit r_inv = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int e;
    cyc++;
    ps_done = 1'b0;
    if (pend) begin
      dly--;
      if (dly == 0) begin
        ps_done = 1'b1;
        pend = 0;
        pos += pdir ? 1 : -1;
        garb = 8;
      end
    end
    if (ps_en) begin
      if (pend) viol++;
      if (!first_seen) begin first_seen = 1; first_dir = ps_dir; end
      pend = 1; dly = 3; pdir = ps_dir;
    end
    e = r_inv ? -pos : pos;
    cap_valid = (cyc % 3 != 2);
    if (!cap_valid) cap_word = 8'h0F;
    else if (garb > 0) begin garb--; cap_word = 8'hF0; end
    else if (r_w > 0 && e >= r_lo && e < r_lo + r_w) begin
      if (r_mode == 0) begin flip = !flip; cap_word = flip ? 8'h55 : 8'hAA; end
      else cap_word = 8'h00;
    end else cap_word = r_inv ? 8'hAA : 8'h55;
  end

  task automatic run(input int lo, input int w, input int mode, input bit inv,
                     input int mx, output bit timed_out);
    int t;
    timed_out = 0;
    @(negedge clk);
    r_lo = lo; r_w = w; r_mode = mode; r_inv = inv;
    pos = 0; garb = 8; first_seen = 0;
    invert_dir = inv; max_steps = SW'(mx); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy after start", busy, 1);
    chk("R2 status cleared", aligned | search_err, 0);
    t = 0;
    while (busy && t < 120000) begin @(negedge clk); t++; end
    if (busy) begin
      timed_out = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=busy expected=idle");
    end
  endtask

  // lo, w, mode, inv, max, exp_aligned, exp_pos
  localparam int VEC [6][7] = '{
    '{5, 4, 0, 0, 100, 1, 7},   // R7 R8 typical region
    '{3, 1, 1, 1, 100, 1, 3},   // R4 R6 single-step region, inverted, stuck word
    '{0, 3, 0, 0, 100, 1, 1},   // R7 region at the start phase
    '{6, 5, 1, 1, 11, 1, 8},    // R9 limit met exactly
    '{6, 5, 0, 0, 10, 0, 10},   // R9 one step short
    '{2, 2, 0, 0, 0, 1, 3}      // R10 zero selects default
  };

  initial begin
    bit to;
    rst = 1'b1; start = 1'b0; invert_dir = 1'b0; max_steps = '0;
    repeat (4) @(negedge clk);
    chk("R1 ps_en", ps_en, 0);
    chk("R1 busy", busy, 0);
    chk("R1 aligned/err", aligned | search_err, 0);
    chk("R1 phase_pos", phase_pos, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      run(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3] != 0, VEC[i][4], to);
      chk("R8 aligned", aligned, VEC[i][5]);
      chk("R9 search_err", search_err, 1 - VEC[i][5]);
      chk("R11 phase_pos", phase_pos, VEC[i][6]);
      chk("R5 R6 model position", (VEC[i][3] != 0) ? -pos : pos, VEC[i][6]);
      chk("R4 first step direction", first_dir, (VEC[i][3] != 0) ? 0 : 1);
    end

    // R10: no edge at all, default limit of 1120 forward steps
    run(0, 0, 0, 0, 0, to);
    chk("R10 error flagged", search_err, 1);
    chk("R10 phase_pos at default limit", phase_pos, 1120);

    chk("R3 no overlapping requests", viol, 0);

    // R2: restart after an error clears status
    run(1, 2, 0, 1, 50, to);
    chk("R2 restart locks", aligned, 1);
    chk("R11 restart position", phase_pos, 2);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule